// File: doc/BRIEF.md
# Prioritized Interrupt Index Generator

This block gathers eight single-cycle event pulses from a data-converter peripheral and keeps each one in a sticky raw status bit. A software mask selects which of the stored flags may raise the CPU interrupt. The block presents the single most urgent enabled flag as a sparse four-bit code on a simple register-read port. Software reads the code register to learn which event to service. That read also clears the flag it returned, so repeated reads walk through the pending events from most to least urgent and then return zero.

Software can also drop any set of flags by writing ones to a clear register. A new event that lands in the same cycle as a clear of its own flag is kept. The interrupt line is the registered OR of all enabled pending flags. The register port is a plain strobe interface: `rd_en`/`wr_en` with an address, combinational read data, and side effects applied at the clock edge of the access.

Top module: `irq_index_gen`

## Requirements
- R1: After reset, the raw flags (address 0), the mask (address 1), the masked status (address 2) and the index (address 3) all read zero, and `irq_o` is low.
- R2: A one on `evt_i[k]` at a clock edge sets raw flag bit k, and the bit stays set until it is cleared. Setting does not depend on the mask. The bit order is: 0 module ready, 1 FIFO full, 2 FIFO quarter empty, 3 FIFO half empty, 4 FIFO three-quarter empty, 5 FIFO empty, 6 FIFO underrun, 7 DMA block done.
- R3: Writing address 1 loads the mask from `wdata`, and reading address 1 returns it. Address 2 reads as the raw flags ANDed with the mask.
- R4: The index reports event bit 0 as 0x2 and event bit k (k from 1 to 7) as 0x8+k, in `rdata[3:0]` with the upper bits zero.
- R5: Among the flags that are both raw-set and enabled, the lowest bit number wins the index. When none is enabled and pending, the index is 0x0.
- R6: A read of address 3 clears only the raw flag whose code it returned. The next read returns the next enabled pending code, or 0x0. A read that returns 0x0 clears nothing, and disabled flags are untouched.
- R7: A write to address 4 clears every raw flag whose `wdata` bit is one and leaves the other flags as they are.
- R8: When an event pulse and a clear (a write to address 4 or an index read) hit the same flag in the same cycle, the flag ends up set.
- R9: `irq_o` equals the OR of the masked flags as they were before the previous clock edge, so it is one register stage behind the status.
- R10: Reads of addresses 0, 1, 2 and unmapped addresses change no state. Writes to addresses 0, 2, 3 and unmapped addresses are ignored. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle event pulses, one per event bit |
| rd_en | input | 1 | Read strobe; a read of address 3 has a side effect at this edge |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| irq_o | output | 1 | Registered CPU interrupt request |

## Verification
The assertions assume that `rd_en` and `wr_en` are never both high in one cycle, and that event inputs are clean synchronous pulses sampled only at rising edges. The flag properties also assume that an index read is the only clear source other than the clear register. The stimulus drives one access at a time, never both strobes together. Event bits are drawn sparsely at random, with directed cycles that place a pulse on exactly the flag being cleared.

// File: rtl/irq_idx_pkg.sv
package irq_idx_pkg;

  localparam int unsigned EVT_N  = 8;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_RAW   = 3'd0,
    A_MASK  = 3'd1,
    A_MSTAT = 3'd2,
    A_INDEX = 3'd3,
    A_CLEAR = 3'd4
  } reg_addr_e;

  // Sparse code: highest-urgency event uses 0x2, the rest 0x9 upward.
  function automatic logic [IDX_W-1:0] evt_code(input int unsigned k);
    logic [IDX_W-1:0] c;
    if (k == 0) c = IDX_W'(2);
    else        c = IDX_W'(8 + k);
    return c;
  endfunction

endpackage

// File: rtl/irq_raw_flags.sv
module irq_raw_flags #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] raw_o
);

  logic [N-1:0] raw_q;
  logic [N-1:0] raw_d;
  logic         raw_en;

  always_comb begin
    // set is applied after clear: a colliding event survives
    raw_d  = (raw_q & ~clr_i) | set_i;
    raw_en = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end

  assign raw_o = raw_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chk
      p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[g] |=> raw_q[g]);
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q[g] && !clr_i[g]) |=> raw_q[g]);
      p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[g] && !set_i[g]) |=> !raw_q[g]);
      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[g] && set_i[g]) |=> raw_q[g]);
      p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_q[g] && !set_i[g]) |=> !raw_q[g]);
    end
  endgenerate

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_idx_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] code_o
);

  always_comb begin
    grant_o = '0;
    code_o  = '0;
    // scan from lowest urgency to highest so the last hit wins
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        grant_o    = '0;
        grant_o[k] = 1'b1;
        code_o     = IW'(evt_code(k));
      end
    end
  end

endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_idx_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 4,
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  raw_i,
  input  logic [N-1:0]  masked_i,
  input  logic [N-1:0]  grant_i,
  input  logic [IW-1:0] code_i,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  clr_o,
  output logic [DW-1:0] rdata
);

  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;
  logic         mask_en;
  logic         hit_mask_wr;
  logic         hit_clr_wr;
  logic         hit_idx_rd;

  always_comb begin
    hit_mask_wr = wr_en && (addr == AW'(A_MASK));
    hit_clr_wr  = wr_en && (addr == AW'(A_CLEAR));
    hit_idx_rd  = rd_en && (addr == AW'(A_INDEX));
    mask_en     = hit_mask_wr;
    mask_d      = wdata[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_comb begin
    clr_o = '0;
    if (hit_clr_wr) clr_o = clr_o | wdata[N-1:0];
    if (hit_idx_rd) clr_o = clr_o | grant_i;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      AW'(A_RAW):   rdata[N-1:0]  = raw_i;
      AW'(A_MASK):  rdata[N-1:0]  = mask_q;
      AW'(A_MSTAT): rdata[N-1:0]  = masked_i;
      AW'(A_INDEX): rdata[IW-1:0] = code_i;
      default:      rdata         = '0;
    endcase
  end

  assign mask_o = mask_q;

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mask_wr |=> (mask_q == $past(wdata[N-1:0])));
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_mask_wr |=> $stable(mask_q));
  p_read_clear_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_idx_rd |-> $onehot0(grant_i));
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

endmodule

// File: rtl/irq_index_gen.sv
module irq_index_gen
  import irq_idx_pkg::*;
#(
  parameter int unsigned NUM_EVT = EVT_N,
  parameter int unsigned IDX_WID = IDX_W,
  parameter int unsigned DAT_WID = DATA_W,
  parameter int unsigned ADR_WID = ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [ADR_WID-1:0] addr,
  input  logic [DAT_WID-1:0] wdata,
  output logic [DAT_WID-1:0] rdata,
  output logic               irq_o
);

  logic [NUM_EVT-1:0] raw;
  logic [NUM_EVT-1:0] mask;
  logic [NUM_EVT-1:0] masked;
  logic [NUM_EVT-1:0] grant;
  logic [NUM_EVT-1:0] clr;
  logic [IDX_WID-1:0] code;
  logic               irq_q;
  logic               irq_d;

  irq_raw_flags #(.N(NUM_EVT)) i_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_i),
    .clr_i (clr),
    .raw_o (raw)
  );

  assign masked = raw & mask;

  irq_prio_enc #(.N(NUM_EVT), .IW(IDX_WID)) i_enc (
    .req_i   (masked),
    .grant_o (grant),
    .code_o  (code)
  );

  irq_regif #(.N(NUM_EVT), .IW(IDX_WID), .DW(DAT_WID), .AW(ADR_WID)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .raw_i    (raw),
    .masked_i (masked),
    .grant_i  (grant),
    .code_i   (code),
    .mask_o   (mask),
    .clr_o    (clr),
    .rdata    (rdata)
  );

  always_comb irq_d = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(raw & mask))));
  p_idx_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) == ((raw & mask) == '0));
  p_grant_in_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~(raw & mask)) == '0) && $onehot0(grant));
  p_read_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_WID'(A_INDEX) && (grant & evt_i) == '0 && grant != '0)
      |=> ((raw & $past(grant)) == '0));

endmodule

// File: tb/test_irq_index_gen.sv
module test_irq_index_gen;

  logic       clk;
  logic       rst_n;
  logic [7:0] evt_i;
  logic       rd_en;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq_o;

  int n_chk;
  int n_bad;

  logic [7:0] m_raw;
  logic [7:0] m_mask;

  irq_index_gen i_irq_index_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq_o (irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] f_grant(input logic [7:0] req);
    for (int k = 0; k < 8; k++) if (req[k]) return 8'(1 << k);
    return 8'h00;
  endfunction

  function automatic logic [7:0] f_index(input logic [7:0] req);
    for (int k = 0; k < 8; k++)
      if (req[k]) return (k == 0) ? 8'h02 : 8'(8 + k);
    return 8'h00;
  endfunction

  function automatic logic [7:0] f_read(input logic [2:0] a);
    case (a)
      3'd0:    return m_raw;
      3'd1:    return m_mask;
      3'd2:    return m_raw & m_mask;
      3'd3:    return f_index(m_raw & m_mask);
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check read data before the edge,
  // apply the model after the edge and check the registered interrupt.
  task automatic cyc(input string req, input logic [7:0] ev, input logic rd,
                     input logic wr, input logic [2:0] a, input logic [7:0] wd);
    logic [7:0] clr;
    logic       exp_irq;
    @(negedge clk);
    evt_i = ev; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    #1;
    if (rd) check(req, rdata, f_read(a));
    exp_irq = |(m_raw & m_mask);
    clr = 8'h00;
    if (wr && a == 3'd4) clr = clr | wd;
    if (rd && a == 3'd3) clr = clr | f_grant(m_raw & m_mask);
    @(posedge clk);
    if (wr && a == 3'd1) m_mask = wd;
    m_raw = (m_raw & ~clr) | ev;
    #1;
    check("R9", {7'd0, irq_o}, {7'd0, exp_irq});
    evt_i = 8'h00; rd_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] ev;
    int unsigned r;
    n_chk = 0; n_bad = 0;
    m_raw = 8'h00; m_mask = 8'h00;
    evt_i = 8'h00; rd_en = 1'b0; wr_en = 1'b0; addr = 3'd0; wdata = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    void'($urandom(32'd20251));

    // R1 reset state
    check("R1", {7'd0, irq_o}, 8'h00);
    for (int a = 0; a < 4; a++) cyc("R1", 8'h00, 1'b1, 1'b0, 3'(a), 8'h00);

    // R2 flags set while masked off; R6 index read of zero clears nothing
    cyc("R2", 8'hA5, 1'b0, 1'b0, 3'd0, 8'h00);
    cyc("R2", 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
    cyc("R6", 8'h00, 1'b1, 1'b0, 3'd3, 8'h00);
    cyc("R6", 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);

    // R10 writes to read-only addresses ignored, other reads have no effect
    cyc("R10", 8'h00, 1'b0, 1'b1, 3'd0, 8'h00);
    cyc("R10", 8'h00, 1'b0, 1'b1, 3'd3, 8'hFF);
    cyc("R10", 8'h00, 1'b0, 1'b1, 3'd6, 8'hFF);
    cyc("R10", 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
    cyc("R10", 8'h00, 1'b1, 1'b0, 3'd7, 8'h00);

    // R3 mask and masked status
    cyc("R3", 8'h00, 1'b0, 1'b1, 3'd1, 8'hFF);
    cyc("R3", 8'h00, 1'b1, 1'b0, 3'd1, 8'h00);
    cyc("R3", 8'h5A, 1'b1, 1'b0, 3'd2, 8'h00);

    // R4 R5 R6 walk all codes by repeated index reads
    for (int k = 0; k < 9; k++) cyc("R4 R5 R6", 8'h00, 1'b1, 1'b0, 3'd3, 8'h00);
    cyc("R6", 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);

    // R6 disabled flag untouched by index read
    cyc("R6", 8'h00, 1'b0, 1'b1, 3'd1, 8'hFE);
    cyc("R6", 8'h03, 1'b0, 1'b0, 3'd0, 8'h00);
    cyc("R6", 8'h00, 1'b1, 1'b0, 3'd3, 8'h00);
    cyc("R6", 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);

    // R7 clear register
    cyc("R7", 8'hF0, 1'b0, 1'b0, 3'd0, 8'h00);
    cyc("R7", 8'h00, 1'b0, 1'b1, 3'd4, 8'h30);
    cyc("R7", 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);

    // R8 collisions
    cyc("R8", 8'h40, 1'b0, 1'b1, 3'd4, 8'hFF);
    cyc("R8", 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
    cyc("R8", 8'h40, 1'b1, 1'b0, 3'd3, 8'h00);
    cyc("R8", 8'h00, 1'b1, 1'b0, 3'd3, 8'h00);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      r  = $urandom;
      ev = ((r[3:0] == 4'd0) ? 8'(1 << r[6:4]) : 8'h00);
      if (r[9:8] == 2'd3 && (m_raw & m_mask) != 8'h00)
        ev = ev | f_grant(m_raw & m_mask);
      case (r[12:10])
        3'd0, 3'd1, 3'd2: cyc("R5 R6", ev, 1'b1, 1'b0, 3'd3, 8'h00);
        3'd3:             cyc("R2 R3", ev, 1'b1, 1'b0, 3'(r[15:13]), 8'h00);
        3'd4:             cyc("R7 R8", ev, 1'b0, 1'b1, 3'd4, 8'(r[23:16]));
        3'd5:             cyc("R3", ev, 1'b0, 1'b1, 3'd1, 8'(r[31:24]));
        default:          cyc("R2", ev, 1'b0, 1'b0, 3'd0, 8'h00);
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule